// File: doc/BRIEF.md
# Power-of-Two Peripheral Clock-Enable Generator

This block derives a gated clock-enable strobe for a peripheral from the system clock. The strobe is one system-clock cycle wide. Its rate is the system clock divided by a power of two from 1 to 128. Software controls the block through one 32-bit control word, which it reaches with a plain address/write/read strobe. The word has a three-bit ratio code, an apply bit and an enable bit. Every other bit is plain read/write storage.

Writing the ratio code does not change the running rate. The code is copied into the working ratio only by a write that moves the apply bit from 0 to 1. Until that write, the divider keeps the ratio it last took in. Both an apply and a re-enable restart the divide count from zero, so no strobe comes early after either event. A read always shows the stored word, whether or not the ratio in it has been applied.

Top module: `pdiv_clkgen`

## Requirements
- R1: A write with `bus_wr` high and `bus_addr` equal to 0x34 stores all 32 bits of `bus_wdata`. A write to any other address leaves the word unchanged. When `bus_rd` is high and `bus_addr` is 0x34, `bus_rdata` shows the stored word in the same cycle; otherwise `bus_rdata` is zero.
- R2: A clock edge with `rst_n` low loads the control word with 0x000038DD: ratio code (bits 16:14) 000, apply bit (bit 13) 1, enable bit (bit 12) 1. It also sets the working ratio to divide-by-1.
- R3: The ratio code at bits 16:14 is copied into the working ratio only by a write that takes bit 13 from 0 to 1. A write while bit 13 already holds 1, or a write of 0 to it, neither changes the ratio nor restarts the count.
- R4: While enable bit 12 of the stored word is 0, `pclk_en` stays low, even if a new ratio is applied meanwhile.
- R5: With ratio code n (000 to 111) applied and enable at 1, `pclk_en` is high for one cycle in every 2^n cycles. Code 000 makes it high on every cycle.
- R6: After an applying write, cycle k counts from 0 for the cycle that follows the write edge. The first strobe at the new ratio falls in cycle 2^n-1, and no strobe comes earlier.
- R7: When enable goes from 0 back to 1, the count restarts from zero with the working ratio unchanged. The first strobe falls in cycle 2^n-1 after that write.
- R8: A read shows a ratio code that has been written but not yet applied, while `pclk_en` keeps running at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| pclk_en | output | 1 | Divided, gated one-cycle clock-enable strobe |

## Verification
The strobe train is checked cycle by cycle against an expected queue at ratios 1, 2, 4, 8 and 128. This separates a wrong period from a wrong phase after a restart. Prepare-then-commit write pairs are set against a repeated apply with the bit already at 1, which shows whether the working ratio follows the apply edge or merely follows the field. Applying a ratio while disabled, and an off/on toggle of enable, show whether the count restart and ratio retention are tied to the enable bit. Writes and reads at a foreign address, plus a reset mid-run, show the decode and the default.

// File: rtl/pdiv_pkg.sv
// Shared constants for the clock-enable generator: control word layout
// and reset value. Field positions are fixed because software decodes them.
package pdiv_pkg;
    localparam int          DATA_W    = 32;
    localparam int          SEL_LSB   = 14;
    localparam int          APPLY_BIT = 13;
    localparam int          EN_BIT    = 12;
    localparam logic [31:0] CTRL_RST  = 32'h0000_38DD;
endpackage

// File: rtl/pdiv_ctrl_reg.sv
// Control word storage with single-address decode.
// Assumes one-cycle write strobes; read data is combinational.
module pdiv_ctrl_reg
    import pdiv_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              wr_hit,
    output logic [DATA_W-1:0] bus_rdata
);
    logic addr_hit;

    // Address compare shared by read and write paths.
    assign addr_hit = (bus_addr == REG_OFFSET);
    assign wr_hit   = bus_wr && addr_hit;

    // Store the whole word on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else if (wr_hit)
            ctrl_q <= bus_wdata;
    end

    // Same-cycle readback; zero when not addressed.
    always_comb begin
        if (bus_rd && addr_hit)
            bus_rdata = ctrl_q;
        else
            bus_rdata = '0;
    end
endmodule

// File: rtl/pdiv_apply.sv
// Apply-edge detector and working-ratio latch.
// A write that turns the stored apply bit from 0 to 1 loads the ratio
// and requests a counter restart in the same edge.
module pdiv_apply #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             apply_cur,
    input  logic             apply_wr,
    input  logic [SEL_W-1:0] sel_wr,
    output logic [SEL_W-1:0] ratio_q,
    output logic             restart_o
);
    // Rising write of the apply bit, judged against the stored value.
    assign restart_o = wr_hit && apply_wr && !apply_cur;

    // Working ratio, changed only by an apply edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ratio_q <= '0;
        else if (restart_o)
            ratio_q <= sel_wr;
    end
endmodule

// File: rtl/pdiv_counter.sv
// Divide counter and output gating. The counter wraps at 2^ratio-1 and
// is held at zero while disabled or restarted. Assumes ratio changes
// only together with a restart.
module pdiv_counter #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] ratio_i,
    output logic             pclk_en
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_mask;
    logic             at_term;

    // Terminal value has its low 'ratio' bits set, one comparator per bit.
    for (genvar b = 0; b < CNT_W; b++) begin : g_mask
        assign term_mask[b] = (ratio_i > SEL_W'(b));
    end

    assign at_term = (cnt_q == term_mask);

    // Count cycles within one divided period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en_i || restart_i || at_term)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Gated one-cycle strobe at the end of each period.
    assign pclk_en = en_i && at_term;
endmodule

// File: rtl/pdiv_clkgen.sv
// Top: power-of-two peripheral clock-enable generator.
// Connects the control word, the apply latch and the divide counter.
module pdiv_clkgen
    import pdiv_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h34,
    parameter int                SEL_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pclk_en
);
    logic [DATA_W-1:0] ctrl_q;
    logic              wr_hit;
    logic [SEL_W-1:0]  ratio_q;
    logic              restart;

    pdiv_ctrl_reg #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .ctrl_q    (ctrl_q),
        .wr_hit    (wr_hit),
        .bus_rdata (bus_rdata)
    );

    pdiv_apply #(.SEL_W(SEL_W)) u_apply (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .apply_cur (ctrl_q[APPLY_BIT]),
        .apply_wr  (bus_wdata[APPLY_BIT]),
        .sel_wr    (bus_wdata[SEL_LSB +: SEL_W]),
        .ratio_q   (ratio_q),
        .restart_o (restart)
    );

    pdiv_counter #(.SEL_W(SEL_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (ctrl_q[EN_BIT]),
        .restart_i (restart),
        .ratio_i   (ratio_q),
        .pclk_en   (pclk_en)
    );
endmodule

// File: rtl/pdiv_clkgen_chk.sv
// Property checker for pdiv_clkgen, attached by bind.
module pdiv_clkgen_chk
    import pdiv_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h34,
    parameter int                SEL_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              pclk_en,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [SEL_W-1:0]  ratio_q
);
    logic hit;
    assign hit = bus_wr && (bus_addr == REG_OFFSET);

    // R1
    word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ctrl_q == $past(bus_wdata));

    // R1
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(ctrl_q));

    // R3
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctrl_q[APPLY_BIT]) |=> $stable(ratio_q));

    // R3
    apply_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ctrl_q[APPLY_BIT] && bus_wdata[APPLY_BIT])
        |=> ratio_q == $past(bus_wdata[SEL_LSB +: SEL_W]));

    // R4
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[EN_BIT] |-> !pclk_en);

    // R5
    div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[EN_BIT] && ratio_q == '0) |-> pclk_en);

    // R6
    no_short_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ctrl_q[APPLY_BIT] && bus_wdata[APPLY_BIT])
        |=> (ratio_q == '0) || !pclk_en);

    // R7
    no_short_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[EN_BIT]) |-> (ratio_q == '0) || !pclk_en);
endmodule

bind pdiv_clkgen pdiv_clkgen_chk #(
    .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .SEL_W(SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pclk_en   (pclk_en),
    .ctrl_q    (ctrl_q),
    .ratio_q   (ratio_q)
);

// File: tb/pdiv_clkgen_test.sv
// Scoreboard bench: driver tasks queue expected strobe values per cycle,
// a monitor pops them at each falling edge and compares.
module pdiv_clkgen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        pclk_en;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    localparam logic [7:0] OFS = 8'h34;

    always #10 clk = ~clk;

    pdiv_clkgen uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pclk_en(pclk_en)
    );

    function automatic logic [31:0] word(input int sel, input bit ap, input bit en,
                                         input logic [31:0] other);
        return (other & 32'hFFFE_0FFF) | (32'(sel) << 14) | (32'(ap) << 13) | (32'(en) << 12);
    endfunction

    // Monitor: compare strobe with the queued expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (pclk_en !== e) begin
                n_fail++;
                $display("FAIL %s pclk_en actual=%b expected=%b t=%0t", t, pclk_en, e, $time);
            end
        end
    end

    // Entered and left at posedge+1.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    // Queue n cycles of a strobe with given period starting at phase ph.
    task automatic expect_run(input int period, input int ph, input int n, input string t);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(((ph + i) % period) == period - 1);
            tag_q.push_back(t);
        end
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_low(input int n, input string t);
        expect_run(n + 1, 0, n, t);
    endtask

    // Combinational read within the current cycle.
    task automatic read_check(input logic [7:0] a, input logic [31:0] e, input string t);
        #2 bus_addr = a; bus_rd = 1'b1;
        #1 n_chk++;
        if (bus_rdata !== e) begin
            n_fail++;
            $display("FAIL %s bus_rdata actual=%h expected=%h", t, bus_rdata, e);
        end
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R2: default word and divide-by-1
        read_check(OFS, 32'h0000_38DD, "R2");
        expect_run(1, 0, 5, "R2");
        // R1: foreign-address write ignored, foreign read gives zero
        bus_write(8'h30, 32'hFFFF_FFFF);
        read_check(OFS, 32'h0000_38DD, "R1");
        read_check(8'h38, 32'h0, "R1");
        expect_run(1, 0, 3, "R1");
        // R8: field written without apply shows in readback, rate unchanged
        w = word(2, 0, 1, 32'hC300_05A0);
        bus_write(OFS, w);
        read_check(OFS, w, "R8");
        expect_run(1, 0, 3, "R8");
        // R6: commit divide-by-4, first strobe in cycle 3
        bus_write(OFS, word(2, 1, 1, 32'hC300_05A0));
        expect_run(4, 0, 12, "R6");
        // R3: apply bit already 1, new field ignored, phase continues (13 mod 4)
        w = word(7, 1, 1, 32'h0);
        bus_write(OFS, w);
        expect_run(4, 1, 8, "R3");
        read_check(OFS, w, "R1");
        // R5: divide-by-128
        bus_write(OFS, word(7, 0, 1, 32'h0));
        bus_write(OFS, word(7, 1, 1, 32'h0));
        expect_run(128, 0, 260, "R5");
        // R4: disabled output stays low, including an apply while off
        bus_write(OFS, word(7, 1, 0, 32'h0));
        expect_low(20, "R4");
        bus_write(OFS, word(1, 0, 0, 32'h0));
        bus_write(OFS, word(1, 1, 0, 32'h0));
        expect_low(6, "R4");
        // R7: enable on restarts at ratio latched while off
        bus_write(OFS, word(1, 1, 1, 32'h0));
        expect_run(2, 0, 10, "R7");
        bus_write(OFS, word(1, 1, 0, 32'h0));
        expect_low(4, "R7");
        bus_write(OFS, word(1, 1, 1, 32'h0));
        expect_run(2, 0, 6, "R7");
        // R5: back to divide-by-1
        bus_write(OFS, word(0, 0, 1, 32'h0));
        bus_write(OFS, word(0, 1, 1, 32'h0));
        expect_run(1, 0, 4, "R5");
        // R6: divide-by-8, then re-apply mid-period restarts the count
        bus_write(OFS, word(3, 0, 1, 32'h0));
        bus_write(OFS, word(3, 1, 1, 32'h0));
        expect_run(8, 0, 20, "R6");
        bus_write(OFS, word(3, 0, 1, 32'h0));
        bus_write(OFS, word(3, 1, 1, 32'h0));
        expect_run(8, 0, 10, "R6");
        // R2: reset mid-run
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        read_check(OFS, 32'h0000_38DD, "R2");
        expect_run(1, 0, 4, "R2");
        finish_run();
    end
endmodule